// File: doc/BRIEF.md
# Decode-Stage Multicycle Memory Splitter

This block sits in the decode stage of a five-stage integer pipeline. Some memory instructions cannot issue as one operation: doubleword loads and stores, a plain store, and the two atomics (register swap and byte test-and-set). Each of these is expanded into two or three consecutive pipeline slots. A small slot counter, a held copy of the instruction and a few multiplexers drive the expansion. There is no sequencing table.

For every slot the block reports the operation kind (pass-through, address phase, load or store), which 32-bit word is moved, the byte offset from the effective address, and the register-file read and write selects. While slots remain, `busy` stays high so that fetch holds the following instruction on the decode inputs. During that time the inputs are ignored, because the block works from its own held copy.

The atomics follow the same three-slot schedule as a doubleword store. Their store data is latched when the instruction is accepted. That data is therefore already stable on `st_data` during the load slot and stays unchanged through the store slot. A downstream stall freezes the slot in progress.

Top module: `decode_splitter`

## Requirements
- R1: Class encoding on `in_class`: 0 other, 1 double load, 2 store, 3 double store, 4 swap, 5 byte test-and-set (6 and 7 act as other). These take 1, 2, 2, 3, 3 and 3 slots. `busy` is low in the last slot of every instruction.
- R2: `busy` is high in every slot except the last. While `busy` is high, the decode inputs are ignored and the next unstalled cycle moves to the next slot of the same instruction.
- R3: Operation encoding on `slot_op`: 0 pass, 1 address phase, 2 load, 3 store. A memory slot with `slot_hi`=1 uses offset 0. A memory slot with `slot_hi`=0 uses offset 4, which is the word size in bytes. A double store is address phase, then high-word store, then low-word store.
- R4: A double load performs two loads, high word then low word. It writes the even register of the pair first and the odd register second. A double store reads the even register in its second slot and the odd register in its third.
- R5: A store is an address phase followed by one store at offset 0 with `slot_hi`=1 that reads register `in_rd`.
- R6: Swap and test-and-set use address phase, load, then store, all at offset 0 with `slot_hi`=1. The load writes `in_rd`. Swap reads `in_rd` in its address phase. The store slot reads no register.
- R7: When a swap is accepted, `in_rd_data` is latched into `st_data`. When a test-and-set is accepted, all ones are latched. The value is held through the load and store slots.
- R8: While `in_stall` is high, the slot counter and every slot output keep their values.
- R9: An "other" instruction gives one pass slot with no register access. With `in_valid` low and no sequence in progress, `slot_valid` is low and `slot_op` is pass.
- R10: After reset, the block is idle: `slot_valid`, `busy`, both register enables and `st_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode holds an instruction |
| in_class | input | 3 | Decoded instruction class |
| in_rd | input | REG_W | Destination/source data register index |
| in_rd_data | input | DATA_W | Register value to be stored by a swap |
| in_stall | input | 1 | Downstream stall |
| slot_valid | output | 1 | A slot is being issued this cycle |
| slot_op | output | 2 | Slot operation kind |
| slot_hi | output | 1 | High (first) word selected |
| slot_off | output | OFF_W | Byte offset from the effective address |
| rf_rd_en | output | 1 | Register read port in use |
| rf_rd_sel | output | REG_W | Register read index |
| rf_wr_en | output | 1 | Register write scheduled |
| rf_wr_sel | output | REG_W | Register write index |
| st_data | output | DATA_W | Latched atomic store data |
| busy | output | 1 | More slots follow; hold fetch |

## Verification
The bound checker watches, on every cycle, the rules that hold whatever the instruction stream is. It checks that offsets agree with the word select, that low-word accesses use odd registers, that `busy` implies progress to the next slot, that a stall freezes both the counter and the slot outputs, and that latched store data does not move once the load slot is reached. What only the bench scenarios can show is the full per-class slot sequence and the exact register indices. That includes the forced even/odd pairing for odd `in_rd`, the fact that the next instruction, shown on the inputs while busy, is really ignored, and the captured swap data values. These are compared against a queue-based reference, with stalls placed on first, middle and last slots.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

   typedef enum logic [2:0] {
      CLS_OTHER  = 3'd0,
      CLS_LDD    = 3'd1,
      CLS_ST     = 3'd2,
      CLS_STD    = 3'd3,
      CLS_SWAP   = 3'd4,
      CLS_LDSTUB = 3'd5
   } op_class_e;

   typedef enum logic [1:0] {
      SLOT_PASS  = 2'd0,
      SLOT_ADDR  = 2'd1,
      SLOT_LOAD  = 2'd2,
      SLOT_STORE = 2'd3
   } slot_op_e;

   localparam int MAX_SLOTS = 3;

   // number of pipeline slots taken by a class
   function automatic int slot_count(logic [2:0] c);
      case (c)
         CLS_LDD, CLS_ST:                return 2;
         CLS_STD, CLS_SWAP, CLS_LDSTUB:  return 3;
         default:                        return 1;
      endcase
   endfunction

   function automatic logic is_atomic(logic [2:0] c);
      return (c == CLS_SWAP) || (c == CLS_LDSTUB);
   endfunction

endpackage

// File: rtl/splitter_seq.sv
module splitter_seq
   import splitter_pkg::*;
#(
   parameter int REG_W = 5,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       in_class,
   input  logic [REG_W-1:0] in_rd,
   input  logic             in_stall,
   output logic [2:0]       live_cls,
   output logic [REG_W-1:0] live_rd,
   output logic [CNT_W-1:0] cnt,
   output logic             active,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;
   logic [2:0]       cls_q;
   logic [REG_W-1:0] rd_q;
   logic             first_slot;

   assign first_slot = (cnt_q == '0);

   always_comb begin
      live_cls = first_slot ? in_class : cls_q;
      live_rd  = first_slot ? in_rd    : rd_q;
      active   = !first_slot || in_valid;
      last     = (int'(cnt_q) == slot_count(live_cls) - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cls_q <= '0;
         rd_q  <= '0;
      end else if (active && !in_stall) begin
         cnt_q <= last ? '0 : cnt_q + 1'b1;
         if (first_slot) begin
            cls_q <= in_class;
            rd_q  <= in_rd;
         end
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/splitter_slot.sv
module splitter_slot
   import splitter_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter int CNT_W      = 2,
   parameter int OFF_W      = 3,
   parameter int WORD_BYTES = 4
) (
   input  logic             active,
   input  logic [2:0]       cls,
   input  logic [REG_W-1:0] rd,
   input  logic [CNT_W-1:0] cnt,
   output logic [1:0]       op,
   output logic             hi,
   output logic [OFF_W-1:0] off,
   output logic             rd_en,
   output logic [REG_W-1:0] rd_sel,
   output logic             wr_en,
   output logic [REG_W-1:0] wr_sel
);

   localparam logic [OFF_W-1:0] LOW_OFF = OFF_W'(WORD_BYTES);

   logic             step0;
   logic             step2;
   logic [REG_W-1:0] pair_even;
   logic [REG_W-1:0] pair_odd;

   assign step0     = (cnt == '0);
   assign step2     = (cnt == CNT_W'(2));
   assign pair_even = {rd[REG_W-1:1], 1'b0};
   assign pair_odd  = {rd[REG_W-1:1], 1'b1};

   always_comb begin
      op     = SLOT_PASS;
      hi     = 1'b0;
      off    = '0;
      rd_en  = 1'b0;
      rd_sel = '0;
      wr_en  = 1'b0;
      wr_sel = '0;
      if (active) begin
         case (cls)
            CLS_LDD: begin
               op     = SLOT_LOAD;
               hi     = step0;
               off    = step0 ? '0 : LOW_OFF;
               wr_en  = 1'b1;
               wr_sel = step0 ? pair_even : pair_odd;
            end
            CLS_ST: begin
               if (step0) begin
                  op = SLOT_ADDR;
               end else begin
                  op     = SLOT_STORE;
                  hi     = 1'b1;
                  rd_en  = 1'b1;
                  rd_sel = rd;
               end
            end
            CLS_STD: begin
               if (step0) begin
                  op = SLOT_ADDR;
               end else begin
                  op     = SLOT_STORE;
                  hi     = !step2;
                  off    = step2 ? LOW_OFF : '0;
                  rd_en  = 1'b1;
                  rd_sel = step2 ? pair_odd : pair_even;
               end
            end
            CLS_SWAP, CLS_LDSTUB: begin
               if (step0) begin
                  op     = SLOT_ADDR;
                  rd_en  = (cls == CLS_SWAP);
                  rd_sel = (cls == CLS_SWAP) ? rd : '0;
               end else if (!step2) begin
                  op     = SLOT_LOAD;
                  hi     = 1'b1;
                  wr_en  = 1'b1;
                  wr_sel = rd;
               end else begin
                  op = SLOT_STORE;
                  hi = 1'b1;
               end
            end
            default: op = SLOT_PASS;
         endcase
      end
   end

endmodule

// File: rtl/splitter_sdata.sv
module splitter_sdata #(
   parameter int DATA_W   = 32,
   parameter bit FILL_ALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              take_reg,
   input  logic [DATA_W-1:0] reg_data,
   output logic [DATA_W-1:0] st_data
);

   logic [DATA_W-1:0] fill;
   logic [DATA_W-1:0] data_q;

   generate
      if (FILL_ALL) begin : g_fill_word
         assign fill = '1;
      end else begin : g_fill_byte
         assign fill = DATA_W'(8'hFF);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         data_q <= '0;
      else if (capture)
         data_q <= take_reg ? reg_data : fill;
   end

   assign st_data = data_q;

endmodule

// File: rtl/decode_splitter.sv
module decode_splitter
   import splitter_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter int DATA_W   = 32,
   parameter int OFF_W    = 3,
   parameter bit FILL_ALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_class,
   input  logic [REG_W-1:0]  in_rd,
   input  logic [DATA_W-1:0] in_rd_data,
   input  logic              in_stall,
   output logic              slot_valid,
   output logic [1:0]        slot_op,
   output logic              slot_hi,
   output logic [OFF_W-1:0]  slot_off,
   output logic              rf_rd_en,
   output logic [REG_W-1:0]  rf_rd_sel,
   output logic              rf_wr_en,
   output logic [REG_W-1:0]  rf_wr_sel,
   output logic [DATA_W-1:0] st_data,
   output logic              busy
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int CNT_W      = $clog2(MAX_SLOTS);

   generate
      if (REG_W < 2) begin : g_bad_reg
         $error("decode_splitter: REG_W must allow register pairs");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("decode_splitter: DATA_W must be a whole number of bytes");
      end
      if ((1 << OFF_W) <= WORD_BYTES) begin : g_bad_off
         $error("decode_splitter: OFF_W too narrow for the second word offset");
      end
   endgenerate

   logic [2:0]       cls_w;
   logic [REG_W-1:0] rd_w;
   logic [CNT_W-1:0] cnt_w;
   logic             active_w;
   logic             last_w;
   logic             capture_w;

   splitter_seq #(.REG_W(REG_W), .CNT_W(CNT_W)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_class (in_class),
      .in_rd    (in_rd),
      .in_stall (in_stall),
      .live_cls (cls_w),
      .live_rd  (rd_w),
      .cnt      (cnt_w),
      .active   (active_w),
      .last     (last_w)
   );

   splitter_slot #(
      .REG_W(REG_W), .CNT_W(CNT_W), .OFF_W(OFF_W), .WORD_BYTES(WORD_BYTES)
   ) i_slot (
      .active (active_w),
      .cls    (cls_w),
      .rd     (rd_w),
      .cnt    (cnt_w),
      .op     (slot_op),
      .hi     (slot_hi),
      .off    (slot_off),
      .rd_en  (rf_rd_en),
      .rd_sel (rf_rd_sel),
      .wr_en  (rf_wr_en),
      .wr_sel (rf_wr_sel)
   );

   assign capture_w = in_valid && (cnt_w == '0) && !in_stall && is_atomic(in_class);

   splitter_sdata #(.DATA_W(DATA_W), .FILL_ALL(FILL_ALL)) i_sdata (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture_w),
      .take_reg (in_class == CLS_SWAP),
      .reg_data (in_rd_data),
      .st_data  (st_data)
   );

   assign slot_valid = active_w;
   assign busy       = active_w && !last_w;

endmodule

// File: rtl/splitter_chk.sv
module splitter_chk #(
   parameter int REG_W  = 5,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 3,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_stall,
   input logic              slot_valid,
   input logic [1:0]        slot_op,
   input logic              slot_hi,
   input logic [OFF_W-1:0]  slot_off,
   input logic              rf_rd_en,
   input logic [REG_W-1:0]  rf_rd_sel,
   input logic              rf_wr_en,
   input logic [REG_W-1:0]  rf_wr_sel,
   input logic [DATA_W-1:0] st_data,
   input logic              busy,
   input logic [CNT_W-1:0]  cnt
);

   localparam logic [OFF_W-1:0] LOW_OFF = OFF_W'(DATA_W / 8);

   a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < 3);

   a_r2_busy_valid: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> slot_valid);

   a_r2_busy_advance: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !in_stall |=> slot_valid && (cnt == $past(cnt) + 1'b1));

   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) && in_stall |=> (cnt == $past(cnt)) && $stable(slot_op)
         && $stable(slot_off) && $stable(slot_hi) && $stable(rf_rd_sel)
         && $stable(rf_wr_sel) && $stable(busy));

   a_r3_hi_offset: assert property (@(posedge clk) disable iff (!rst_n)
      slot_op[1] && slot_hi |-> slot_off == '0);

   a_r3_lo_offset: assert property (@(posedge clk) disable iff (!rst_n)
      slot_op[1] && !slot_hi |-> slot_off == LOW_OFF);

   a_r4_lo_store_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_op == 2'd3) && !slot_hi |-> rf_rd_en && rf_rd_sel[0]);

   a_r4_lo_load_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_op == 2'd2) && !slot_hi |-> rf_wr_en && rf_wr_sel[0]);

   a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(2)) |-> $stable(st_data));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_valid |-> (slot_op == 2'd0) && !busy && !rf_rd_en && !rf_wr_en);

endmodule

bind decode_splitter splitter_chk #(
   .REG_W(REG_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_stall   (in_stall),
   .slot_valid (slot_valid),
   .slot_op    (slot_op),
   .slot_hi    (slot_hi),
   .slot_off   (slot_off),
   .rf_rd_en   (rf_rd_en),
   .rf_rd_sel  (rf_rd_sel),
   .rf_wr_en   (rf_wr_en),
   .rf_wr_sel  (rf_wr_sel),
   .st_data    (st_data),
   .busy       (busy),
   .cnt        (cnt_w)
);

// File: tb/test_decode_splitter.sv
module test_decode_splitter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_class = 3'd0;
   logic [4:0]  in_rd = 5'd0;
   logic [31:0] in_rd_data = 32'd0;
   logic        in_stall = 1'b0;
   logic        slot_valid;
   logic [1:0]  slot_op;
   logic        slot_hi;
   logic [2:0]  slot_off;
   logic        rf_rd_en;
   logic [4:0]  rf_rd_sel;
   logic        rf_wr_en;
   logic [4:0]  rf_wr_sel;
   logic [31:0] st_data;
   logic        busy;

   always #4 clk = ~clk;

   decode_splitter i_decode_splitter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_rd(in_rd), .in_rd_data(in_rd_data), .in_stall(in_stall),
      .slot_valid(slot_valid), .slot_op(slot_op), .slot_hi(slot_hi),
      .slot_off(slot_off), .rf_rd_en(rf_rd_en), .rf_rd_sel(rf_rd_sel),
      .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel), .st_data(st_data),
      .busy(busy)
   );

   typedef struct {
      bit          v;
      int          op;
      bit          hi;
      int          off;
      bit          rde;
      int          rds;
      bit          wre;
      int          wrs;
      bit          bsy;
      bit          chk_sd;
      logic [31:0] sd;
      bit          first;
      string       tag;
   } exp_t;

   typedef struct {
      int          cls;
      int          rd;
      logic [31:0] data;
   } ins_t;

   exp_t slot_q[$];
   ins_t ins_q[$];
   ins_t cur;
   int   checks = 0;
   int   errors = 0;
   int   stall_mode = 0;
   bit   prev_stall = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t mk(bit v, int op, bit hi, int off, bit rde, int rds,
                               bit wre, int wrs, bit bsy, bit chk_sd,
                               logic [31:0] sd, bit first, string tag);
      exp_t e;
      e.v = v; e.op = op; e.hi = hi; e.off = off; e.rde = rde; e.rds = rds;
      e.wre = wre; e.wrs = wrs; e.bsy = bsy; e.chk_sd = chk_sd; e.sd = sd;
      e.first = first; e.tag = tag;
      return e;
   endfunction

   // expected slots per class, written from the requirements
   function automatic void expand(ins_t i);
      int ev = i.rd & ~1;
      int od = i.rd | 1;
      case (i.cls)
         1: begin // double load, R4
            slot_q.push_back(mk(1, 2, 1, 0, 0, 0, 1, ev, 1, 0, 0, 1, "R4"));
            slot_q.push_back(mk(1, 2, 0, 4, 0, 0, 1, od, 0, 0, 0, 0, "R4"));
         end
         2: begin // store, R5
            slot_q.push_back(mk(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R5"));
            slot_q.push_back(mk(1, 3, 1, 0, 1, i.rd, 0, 0, 0, 0, 0, 0, "R5"));
         end
         3: begin // double store, R3
            slot_q.push_back(mk(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R3"));
            slot_q.push_back(mk(1, 3, 1, 0, 1, ev, 0, 0, 1, 0, 0, 0, "R4"));
            slot_q.push_back(mk(1, 3, 0, 4, 1, od, 0, 0, 0, 0, 0, 0, "R3"));
         end
         4, 5: begin // atomics, R6 and R7
            logic [31:0] sd = (i.cls == 4) ? i.data : 32'hFFFF_FFFF;
            slot_q.push_back(mk(1, 1, 0, 0, i.cls == 4, i.rd, 0, 0, 1, 0, 0, 1, "R6"));
            slot_q.push_back(mk(1, 2, 1, 0, 0, 0, 1, i.rd, 1, 1, sd, 0, "R6"));
            slot_q.push_back(mk(1, 3, 1, 0, 0, 0, 0, 0, 0, 1, sd, 0, "R7"));
         end
         default: // other, R9
            slot_q.push_back(mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9"));
      endcase
   endfunction

   task automatic present(ins_t i);
      in_valid   = 1'b1;
      in_class   = 3'(i.cls);
      in_rd      = 5'(i.rd);
      in_rd_data = i.data;
   endtask

   task automatic compare(exp_t e);
      string t = prev_stall ? "R8" : e.tag;
      chk(slot_valid == e.v, t, "slot_valid", slot_valid, e.v);
      chk(slot_op == 2'(e.op), t, "slot_op", slot_op, e.op);
      chk(busy == e.bsy, e.bsy ? "R2" : "R1", "busy", busy, e.bsy);
      if (e.op >= 2) begin
         chk(slot_hi == e.hi, t, "slot_hi", slot_hi, e.hi);
         chk(slot_off == 3'(e.off), t, "slot_off", slot_off, e.off);
      end
      chk(rf_rd_en == e.rde, t, "rf_rd_en", rf_rd_en, e.rde);
      if (e.rde) chk(rf_rd_sel == 5'(e.rds), t, "rf_rd_sel", rf_rd_sel, e.rds);
      chk(rf_wr_en == e.wre, t, "rf_wr_en", rf_wr_en, e.wre);
      if (e.wre) chk(rf_wr_sel == 5'(e.wrs), t, "rf_wr_sel", rf_wr_sel, e.wrs);
      if (e.chk_sd) chk(st_data == e.sd, "R7", "st_data", st_data, e.sd);
   endtask

   task automatic step();
      bit st;
      ins_t junk;
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      st = (stall_mode == 1) ? (lfsr[1:0] == 2'b00) :
           (stall_mode == 2) ? lfsr[0] : 1'b0;
      if (slot_q.size() == 0) begin
         if (ins_q.size() > 0) begin
            cur = ins_q.pop_front();
            expand(cur);
            present(cur);
         end else begin
            in_valid = 1'b0;
         end
      end else if (slot_q[0].first) begin
         present(cur);
      end else if (ins_q.size() > 0) begin
         present(ins_q[0]); // following instruction waits on the inputs
      end else begin
         junk.cls = 3; junk.rd = 7; junk.data = 32'h5A5A_0F0F;
         present(junk);
      end
      in_stall = st;
      #1;
      if (slot_q.size() > 0) begin
         compare(slot_q[0]);
         if (!st) void'(slot_q.pop_front());
         prev_stall = st;
      end else begin
         // R9 idle: no sequence and no valid input
         compare(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9"));
         prev_stall = 1'b0;
      end
   endtask

   task automatic add(int cls, int rd, logic [31:0] data);
      ins_t i;
      i.cls = cls; i.rd = rd; i.data = data;
      ins_q.push_back(i);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      // R10 reset state
      #1;
      chk(slot_valid == 1'b0, "R10", "slot_valid in reset", slot_valid, 0);
      chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
      chk(st_data == 32'd0, "R10", "st_data in reset", st_data, 0);
      chk(rf_wr_en == 1'b0 && rf_rd_en == 1'b0, "R10", "rf enables in reset",
          {rf_rd_en, rf_wr_en}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int round = 0; round < 3; round++) begin
         stall_mode = round;
         add(1, 7, 0);             // double load, odd rd forces pair 6/7
         add(3, 10, 0);            // double store, pair 10/11
         add(4, 3, 32'hDEAD_BEEF); // swap
         add(0, 1, 0);             // other
         add(2, 31, 0);            // store
         add(5, 0, 32'h1234_5678); // test-and-set, data ignored
         add(1, 30, 0);
         add(4, 17, 32'h0BAD_F00D);
         add(3, 31, 0);
         add(6, 2, 0);             // unused code, acts as other
         add(4, 9, 32'h0000_0001);
         add(5, 13, 32'h0);
         while (ins_q.size() > 0 || slot_q.size() > 0) step();
         repeat (3) step();
      end
      summary();
   end

endmodule